// File: doc/BRIEF.md
# ECC-Protected Word Array with Partial-Store Merge

This block is a small on-chip data array in which every 32-bit word is kept together with 7 check bits. The check bits form a single-error-correcting, double-error-detecting code over the whole word. A store that writes all four bytes of a word is encoded and written in one pass. A store that writes only some of the bytes cannot be encoded on its own, because the check bits depend on bytes the store does not carry. For such a store the block reads the old word, repairs a single-bit fault if there is one, merges in the enabled bytes, re-encodes the result and writes it back.

The request port takes one access per cycle: reads, full-word stores and partial stores. While a partial store is between its read and its write, `req_ready` is low and no other access is taken, so the merge is atomic with respect to every other access. Reads return corrected data with a single-error pulse and an uncorrectable-error pulse. A test-only port flips chosen stored bits so that both fault paths can be exercised.

Top module: `ecc_word_array`

## Requirements
- R1: After synchronous active-low reset, `req_ready` is 1, `rd_valid` is 0, and every word reads back as 0 with both error flags low.
- R2: A store with `req_be` = 4'b1111 is accepted with no stall: `req_ready` stays 1 in the following cycle, and a later read returns the stored data.
- R3: Each word is stored as 39 bits. Stored bit k-1 holds code position k for k = 1..38, the check bits sit at positions 1, 2, 4, 8, 16 and 32, data bits fill the other positions in ascending order, and stored bit 38 is the even parity of the other 38 bits. A flip of any single stored bit is corrected on read.
- R4: A store with a byte enable that is neither all ones nor all zeros holds `req_ready` low for exactly one cycle after it is accepted. Afterwards the word holds the new bytes where `req_be[b]` is 1 (byte b = bits 8b+7..8b) and the old bytes elsewhere.
- R5: A read accepted at a clock edge gives `rd_valid` = 1 with its data in the cycle that follows that edge, and `rd_valid` is 0 in every other cycle.
- R6: A read of a word with one flipped stored bit returns the original data with `rd_corrected` = 1 and `rd_uncorr` = 0. A read does not repair the stored word, so a second read flags it again.
- R7: A read of a word with two flipped stored bits gives `rd_uncorr` = 1 and `rd_corrected` = 0. The two flags are never high together and are only high with `rd_valid`.
- R8: A partial store to a word with one flipped bit merges into the corrected old data, and the word reads back clean afterwards.
- R9: A partial store to a word with two flipped bits writes nothing. `store_abort` is 1 for one cycle, two cycles after acceptance, and the word still reads as uncorrectable afterwards.
- R10: A store with `req_be` = 4'b0000 does not stall and leaves the word unchanged.
- R11: `inj_en` XORs `inj_mask` into the stored word at `inj_addr` at the next clock edge. A full-word store replaces a damaged word with a clean one.
- R12: A request held on the port during a partial-store stall is accepted in the cycle after the stall ends, and it sees the merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Byte enables of a store |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 32 | Corrected read data |
| rd_corrected | output | 1 | Read found and fixed one bit error |
| rd_uncorr | output | 1 | Read found an uncorrectable error |
| store_abort | output | 1 | Partial store dropped because of an uncorrectable old word |
| inj_en | input | 1 | Test only: flip stored bits |
| inj_addr | input | 4 | Test only: word to damage |
| inj_mask | input | 39 | Test only: stored bits to flip |

## Verification
A read's data and flags are due in the cycle after its accepting edge. The bench pushes the expected item into a queue just before that edge and pops it at the falling edge that follows. A partial store must show `req_ready` low at the first falling edge after acceptance. Its `store_abort` result is sampled at the second falling edge, and the bench counts the stall cycles a held request waits to be accepted. Expected contents come from a data model and a per-word count of injected flips, so correction and abort outcomes follow from the stimulus alone.

// File: rtl/ecc_pkg.sv
// Package: shared widths and types for the ECC word array.
// Assumes the data word is a whole number of bytes. The Hamming check-bit
// count is derived from the data width.
package ecc_pkg;
    parameter int DATA_W = 32;
    localparam int BE_W = DATA_W / 8;

    // Smallest p with 2**p >= DATA_W + p + 1.
    function automatic int ham_checks(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    localparam int HAM_P   = ham_checks(DATA_W);
    localparam int HAM_W   = DATA_W + HAM_P;
    localparam int STORE_W = HAM_W + 1;

    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [STORE_W-1:0] code_t;
    typedef logic [BE_W-1:0]    be_t;

    typedef enum logic {ST_IDLE, ST_MERGE} rmw_state_e;

    function automatic bit is_pow2(input int k);
        return (k & (k - 1)) == 0;
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
// Module: ecc_encoder
// Turns a data word into its stored form. Code position k is stored bit k-1,
// check bits sit at the power-of-two positions, and the top stored bit is the
// even parity of all lower bits. Purely combinational.
module ecc_encoder
    import ecc_pkg::*;
(
    input  word_t data,
    output code_t code
);
    logic [HAM_W-1:0] ham;

    // Place data bits, then compute each check bit over its positions.
    always_comb begin
        int d;
        logic par;
        ham = '0;
        d = 0;
        for (int pos = 1; pos <= HAM_W; pos++) begin
            if (!is_pow2(pos)) begin
                ham[pos-1] = data[d];
                d++;
            end
        end
        for (int p = 0; p < HAM_P; p++) begin
            par = 1'b0;
            for (int pos = 1; pos <= HAM_W; pos++) begin
                if (pos[p]) par = par ^ ham[pos-1];
            end
            ham[(1 << p) - 1] = par;
        end
        code = {^ham, ham};
    end
endmodule

// File: rtl/ecc_decoder.sv
// Module: ecc_decoder
// Checks a stored word, fixes a single flipped bit and flags a double fault.
// Assumes the layout written by ecc_encoder. Purely combinational.
module ecc_decoder
    import ecc_pkg::*;
(
    input  code_t code,
    output word_t data,
    output logic  single_err,
    output logic  double_err
);
    logic [HAM_P-1:0] syn;
    logic             ovp;
    logic [HAM_W-1:0] fixed;

    // Syndrome is the XOR of the positions of all set bits.
    always_comb begin
        syn = '0;
        for (int pos = 1; pos <= HAM_W; pos++) begin
            if (code[pos-1]) syn = syn ^ HAM_P'(pos);
        end
        ovp = ^code;
    end

    // Classify: odd overall parity with a valid position is a single fault.
    always_comb begin
        single_err = ovp && (int'(syn) <= HAM_W);
        double_err = (!ovp && syn != '0) || (ovp && int'(syn) > HAM_W);
    end

    // Flip the located bit and pull the data bits back out.
    always_comb begin
        int d;
        fixed = code[HAM_W-1:0];
        if (ovp && syn != '0 && int'(syn) <= HAM_W)
            fixed[int'(syn)-1] = ~fixed[int'(syn)-1];
        data = '0;
        d = 0;
        for (int pos = 1; pos <= HAM_W; pos++) begin
            if (!is_pow2(pos)) begin
                data[d] = fixed[pos-1];
                d++;
            end
        end
    end
endmodule

// File: rtl/ecc_store.sv
// Module: ecc_store
// Register array of coded words with one write port, one registered read
// port and a test-only bit-flip port. A write wins over a flip aimed at the
// same word in the same cycle. Reset clears every word to the code of zero.
module ecc_store
    import ecc_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  code_t             wr_code,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output code_t             rd_code,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  code_t             inj_mask
);
    code_t mem [DEPTH];

    // Per-word update: clear, write, or fault injection.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (wr_en && int'(wr_addr) == i)
                mem[i] <= wr_code;
            else if (inj_en && int'(inj_addr) == i)
                mem[i] <= mem[i] ^ inj_mask;
        end
    end

    // Registered read of the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_code <= '0;
        else if (rd_en)
            rd_code <= mem[rd_addr];
    end
endmodule

// File: rtl/ecc_rmw_ctrl.sv
// Module: ecc_rmw_ctrl
// Accepts requests and sequences partial stores through read, correct,
// merge and write-back. Assumes the array read is registered, so the old
// word is decoded in the cycle after acceptance. Nothing is accepted in
// that cycle.
module ecc_rmw_ctrl
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  word_t             req_wdata,
    input  be_t               req_be,
    output logic              req_ready,
    input  word_t             dec_data,
    input  logic              dec_double,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output word_t             wr_data,
    output logic              rd_valid,
    output logic              store_abort
);
    rmw_state_e        state;
    logic [ADDR_W-1:0] hold_addr;
    word_t             hold_data;
    be_t               hold_be;
    word_t             merged;
    logic              accept, full_st, part_st;

    // Decode the accepted request type.
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
        full_st   = accept && req_write && (req_be == '1);
        part_st   = accept && req_write && (req_be != '1) && (req_be != '0);
    end

    // Byte-wise merge of held store data over the corrected old word.
    for (genvar b = 0; b < BE_W; b++) begin : g_merge
        assign merged[8*b +: 8] = hold_be[b] ? hold_data[8*b +: 8] : dec_data[8*b +: 8];
    end

    // Drive the array ports from either the request or the merge step.
    always_comb begin
        rd_en   = accept && (!req_write || part_st);
        rd_addr = req_addr;
        if (state == ST_MERGE) begin
            wr_en   = !dec_double;
            wr_addr = hold_addr;
            wr_data = merged;
        end else begin
            wr_en   = full_st;
            wr_addr = req_addr;
            wr_data = req_wdata;
        end
    end

    // Sequencer state and held store fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            hold_addr <= '0;
            hold_data <= '0;
            hold_be   <= '0;
        end else if (state == ST_MERGE) begin
            state <= ST_IDLE;
        end else if (part_st) begin
            state     <= ST_MERGE;
            hold_addr <= req_addr;
            hold_data <= req_wdata;
            hold_be   <= req_be;
        end
    end

    // Result strobes: read data due, partial store dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            store_abort <= 1'b0;
        end else begin
            rd_valid    <= accept && !req_write;
            store_abort <= (state == ST_MERGE) && dec_double;
        end
    end
endmodule

// File: rtl/ecc_word_array.sv
// Module: ecc_word_array (top)
// SECDED-protected word array. Full-word stores are written in one pass;
// partial stores run a one-stall read-correct-merge-write. Reads return
// corrected data and error pulses one cycle after acceptance.
module ecc_word_array
    import ecc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_corrected,
    output logic              rd_uncorr,
    output logic              store_abort,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [STORE_W-1:0] inj_mask
);
    logic              rd_en, wr_en;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    word_t             wr_data, dec_data;
    code_t             wr_code, rd_code;
    logic              dec_single, dec_double;

    ecc_rmw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .req_be,
        .req_ready, .dec_data, .dec_double, .rd_en, .rd_addr, .wr_en, .wr_addr,
        .wr_data, .rd_valid, .store_abort
    );

    ecc_encoder u_enc (.data(wr_data), .code(wr_code));

    ecc_store #(.DEPTH(DEPTH)) u_store (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_code, .rd_en, .rd_addr, .rd_code,
        .inj_en, .inj_addr, .inj_mask
    );

    ecc_decoder u_dec (
        .code(rd_code), .data(dec_data), .single_err(dec_single), .double_err(dec_double)
    );

    // Present read results only while a read result is due.
    always_comb begin
        rd_data      = rd_valid ? dec_data : '0;
        rd_corrected = rd_valid && dec_single;
        rd_uncorr    = rd_valid && dec_double;
    end
endmodule

// File: rtl/ecc_word_array_chk.sv
// Module: ecc_word_array_chk
// Protocol and timing properties of ecc_word_array, attached by bind.
module ecc_word_array_chk
    import ecc_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_write,
    input be_t  req_be,
    input logic req_ready,
    input logic rd_valid,
    input logic rd_corrected,
    input logic rd_uncorr,
    input logic store_abort
);
    logic acc_rd, acc_full, acc_part, acc_none;

    // Classify the request taken this cycle.
    always_comb begin
        acc_rd   = req_valid && req_ready && !req_write;
        acc_full = req_valid && req_ready && req_write && (req_be == '1);
        acc_none = req_valid && req_ready && req_write && (req_be == '0);
        acc_part = req_valid && req_ready && req_write && !(req_be == '1) && !(req_be == '0);
    end

    assert_full_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_full |=> req_ready);
    assert_partial_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_part |=> !req_ready);
    assert_stall_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);
    assert_rd_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd_valid);
    assert_rd_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_rd));
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_corrected && rd_uncorr));
    assert_flags_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_corrected || rd_uncorr) |-> rd_valid);
    assert_abort_after_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        store_abort |-> $past(!req_ready));
    assert_empty_store_no_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_none |=> req_ready);
    assert_nothing_taken_in_merge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !rd_valid);
endmodule

bind ecc_word_array ecc_word_array_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_be(req_be), .req_ready(req_ready), .rd_valid(rd_valid),
    .rd_corrected(rd_corrected), .rd_uncorr(rd_uncorr), .store_abort(store_abort)
);

// File: tb/tb_ecc_word_array.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected read results, a monitor
// pops and compares them at falling edges.
module tb_ecc_word_array;
    import ecc_pkg::*;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = $clog2(DEPTH);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n, req_valid, req_write, req_ready;
    logic [ADDR_W-1:0] req_addr, inj_addr;
    word_t             req_wdata, rd_data;
    be_t               req_be;
    logic              rd_valid, rd_corrected, rd_uncorr, store_abort, inj_en;
    code_t             inj_mask;

    ecc_word_array #(.DEPTH(DEPTH)) dut (.*);

    typedef struct { word_t data; logic corr; logic unc; string tag; } exp_t;
    exp_t  expq [$];
    word_t mdl  [DEPTH];
    int    nerr [DEPTH];
    int    checks = 0, fails = 0, waits = 0;
    logic  exp_abort = 1'b0;
    bit    done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each read result against the queue head.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R5", "unexpected read result", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(rd_uncorr == e.unc, e.tag, "uncorrectable flag", rd_uncorr, e.unc);
                check(rd_corrected == e.corr, e.tag, "corrected flag", rd_corrected, e.corr);
                if (!e.unc) check(rd_data == e.data, e.tag, "read data", rd_data, e.data);
            end
        end
    end

    // Driver: call at a falling edge; returns at the falling edge after acceptance.
    task automatic issue(input bit wr, input int addr, input word_t data,
                         input be_t be, input string tag);
        req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr);
        req_wdata = data; req_be = be;
        waits = 0;
        while (!req_ready) begin waits++; @(negedge clk); end
        if (!wr) begin
            expq.push_back('{mdl[addr], nerr[addr] == 1, nerr[addr] >= 2, tag});
        end else if (be == '1) begin
            mdl[addr] = data; nerr[addr] = 0;
        end else if (be != '0) begin
            exp_abort = (nerr[addr] >= 2);
            if (!exp_abort) begin
                for (int b = 0; b < BE_W; b++)
                    if (be[b]) mdl[addr][8*b +: 8] = data[8*b +: 8];
                nerr[addr] = 0;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(input int addr, input string tag);
        issue(1'b0, addr, '0, '0, tag);
    endtask

    task automatic inject(input int addr, input int b0, input int b1);
        inj_en = 1'b1; inj_addr = ADDR_W'(addr); inj_mask = '0;
        inj_mask[b0] = 1'b1; nerr[addr]++;
        if (b1 >= 0) begin inj_mask[b1] = 1'b1; nerr[addr]++; end
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    // Partial store plus its stall and abort checks.
    task automatic part_store(input int addr, input word_t data, input be_t be,
                              input string tag);
        issue(1'b1, addr, data, be, tag);
        check(req_ready == 1'b0, "R4", "stall after partial store", req_ready, 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R4", "stall ends after one cycle", req_ready, 1);
        check(store_abort == exp_abort, "R9", "store_abort", store_abort, exp_abort);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
        inj_en = 0; inj_addr = '0; inj_mask = '0;
        for (int i = 0; i < DEPTH; i++) begin mdl[i] = '0; nerr[i] = 0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        rd(0, "R1"); rd(7, "R1"); rd(DEPTH-1, "R1");
        settle();

        // R2: full stores without stall, then readback.
        issue(1'b1, 1, 32'hDEADBEEF, 4'hF, "R2");
        check(req_ready == 1'b1, "R2", "no stall on full store", req_ready, 1);
        issue(1'b1, 2, 32'h0000_0001, 4'hF, "R2");
        issue(1'b1, 3, 32'hFFFF_FFFF, 4'hF, "R2");
        issue(1'b1, 4, 32'h8000_0000, 4'hF, "R2");
        rd(1, "R2"); rd(2, "R2"); rd(3, "R2"); rd(4, "R2");
        settle();

        // R5: read result only in the cycle after acceptance.
        rd(3, "R5");
        check(rd_valid == 1'b1, "R5", "rd_valid after read", rd_valid, 1);
        @(negedge clk);
        check(rd_valid == 1'b0, "R5", "rd_valid one cycle only", rd_valid, 0);

        // R4: partial merges with several enable patterns.
        issue(1'b1, 5, 32'h1234_5678, 4'hF, "R4");
        part_store(5, 32'hAAAA_AAAA, 4'b0001, "R4");
        part_store(5, 32'hBBBB_BBBB, 4'b0110, "R4");
        part_store(5, 32'hCCCC_CCCC, 4'b1000, "R4");
        rd(5, "R4");
        part_store(6, 32'h5A5A_5A5A, 4'b1010, "R4");
        rd(6, "R4");
        settle();

        // R10: empty-enable store changes nothing and does not stall.
        issue(1'b1, 5, 32'h0F0F_0F0F, 4'b0000, "R10");
        check(req_ready == 1'b1, "R10", "no stall on empty store", req_ready, 1);
        rd(5, "R10");
        settle();

        // R3/R6: single flips at a check bit, a data bit and the parity bit.
        inject(1, 0, -1);  rd(1, "R6");
        rd(1, "R6");
        inject(2, 10, -1); rd(2, "R3");
        inject(3, 38, -1); rd(3, "R3");
        inject(4, 31, -1); rd(4, "R3");
        settle();

        // R7: double flips are detected.
        inject(7, 3, 20); rd(7, "R7");
        settle();

        // R8: partial store over a single fault merges into corrected data.
        issue(1'b1, 8, 32'hCAFE_F00D, 4'hF, "R8");
        inject(8, 12, -1);
        part_store(8, 32'h0000_1100, 4'b0010, "R8");
        rd(8, "R8");
        settle();

        // R9: partial store over a double fault is dropped.
        issue(1'b1, 9, 32'h1357_9BDF, 4'hF, "R9");
        inject(9, 5, 33);
        part_store(9, 32'hFFFF_FFFF, 4'b0100, "R9");
        rd(9, "R9");
        settle();

        // R11: a full store cleans a damaged word.
        issue(1'b1, 9, 32'h2468_ACE0, 4'hF, "R11");
        rd(9, "R11");
        inject(10, 1, 2); inject(10, 1, -1);  // net one flip on bit 2
        nerr[10] = 1;
        rd(10, "R11");
        settle();

        // R12: a request held during the stall waits one cycle and sees the merge.
        issue(1'b1, 11, 32'h1111_1111, 4'hF, "R12");
        issue(1'b1, 11, 32'h0000_9900, 4'b0010, "R12");
        rd(11, "R12");
        check(waits == 1, "R12", "held read stall cycles", waits, 1);
        settle();

        check(expq.size() == 0, "R5", "pending read results", expq.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule